// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a virtual address onto a physical one through a flat page table that belongs to the running process and sits in ordinary memory. A request carries the virtual address and the kind of access (load, store or instruction fetch). It also carries the table's start address and its length in entries. The upper address bits select an entry. The unit checks the page number against the table length. If it is in range, the unit reads the entry and tests its valid flag and its permission flags. The result is either the stored frame number placed in front of the untouched page offset, or a fault code.

The unit also keeps the usage flags in each entry up to date. Any access that succeeds marks the entry as referenced, and a store that succeeds also marks it dirty. The updated word goes back to memory only when one of those flags actually changes. The unit serves one request at a time and reports `busy` while a lookup is in progress.

Top module: `page_xlate`

## Requirements
- R1: After reset, `resp_valid`, `busy`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: If the page number (address bits above the offset) is greater than or equal to `tbl_size`, the response carries fault code 1 (range). It arrives one cycle after the request, and no memory read takes place. With `tbl_size` = 0, every page is out of range.
- R3: For an in-range page, exactly one table read is issued, at word address `tbl_base` + page number, in the cycle after the request. The entry layout is: bit 0 valid, bit 1 referenced, bit 2 dirty, bit 3 read allowed, bit 4 write allowed, bit 5 execute allowed, and the frame number from bit 6 upward.
- R4: An entry whose valid bit is 0 produces fault code 2 (invalid).
- R5: The access codes are 0 read, 1 write, 2 execute. An access whose permission bit is clear produces fault code 3 (permission). Access code 3 is always refused with code 3.
- R6: When several faults apply, range wins over invalid, and invalid wins over permission.
- R7: A successful access returns fault code 0, with `resp_paddr` equal to the frame number concatenated with the original offset.
- R8: A successful access sets the referenced bit, and a successful write also sets the dirty bit. The entry is written back to the same address, two cycles after the read, only when this changes it.
- R9: A fault never writes to memory.
- R10: `resp_valid` rises 3 cycles after an in-range request, or 4 cycles after one when a write-back happens.
- R11: While `busy` is 1, new requests are ignored and produce no response of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| tbl_base | input | MEM_AW | Word address of the first table entry |
| tbl_size | input | VA_W-OFF_W+1 | Number of table entries |
| busy | output | 1 | A lookup is in progress |
| resp_valid | output | 1 | Response strobe |
| resp_fault | output | 2 | 0 ok, 1 range, 2 invalid, 3 permission |
| resp_paddr | output | FRAME_W+OFF_W | Physical address, meaningful when fault is 0 |
| mem_rd_en | output | 1 | Table read strobe |
| mem_wr_en | output | 1 | Table write-back strobe |
| mem_addr | output | MEM_AW | Table word address |
| mem_wdata | output | FRAME_W+6 | Updated entry |
| mem_rdata | input | FRAME_W+6 | Entry read data, one cycle after the read strobe |

## Verification
The properties assume that the table memory returns its data exactly one cycle after a read strobe. They also assume that nothing else writes the table while a lookup is in flight. The bench memory is a registered array that only the unit writes after start-up, so both hold. The properties further take for granted that table addresses do not wrap. The stimulus keeps `tbl_base` plus the page number inside the bench array. Requests are driven only while the unit is idle, except in the deliberate test that holds the strobe high through a busy window.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_RANGE   = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_PERM    = 2'd3
   } fault_e;

   localparam int BIT_VALID  = 0;
   localparam int BIT_REF    = 1;
   localparam int BIT_DIRTY  = 2;
   localparam int PERM_LO    = 3;
   localparam int PERM_W     = 3;
   localparam int FRAME_LO   = PERM_LO + PERM_W;

endpackage

// File: rtl/xlate_pte_update.sv
module xlate_pte_update
   import xlate_pkg::*;
#(
   parameter int FRAME_W = 20,
   localparam int PTE_W  = FRAME_W + FRAME_LO
) (
   input  logic [PTE_W-1:0]   pte,
   input  logic [1:0]         acc,
   output logic               pte_valid,
   output logic [PERM_W-1:0]  pte_perm,
   output logic [FRAME_W-1:0] pte_frame,
   output logic [PTE_W-1:0]   pte_next,
   output logic               pte_changed
);

   logic [PTE_W-1:0] set_mask;

   assign pte_valid = pte[BIT_VALID];
   assign pte_perm  = pte[PERM_LO +: PERM_W];
   assign pte_frame = pte[FRAME_LO +: FRAME_W];

   always_comb begin
      set_mask = '0;
      set_mask[BIT_REF] = 1'b1;
      if (acc == ACC_WRITE) set_mask[BIT_DIRTY] = 1'b1;
   end

   assign pte_next    = pte | set_mask;
   assign pte_changed = (pte_next != pte);

endmodule

// File: rtl/xlate_rules.sv
module xlate_rules
   import xlate_pkg::*;
(
   input  logic              pte_valid,
   input  logic [PERM_W-1:0] pte_perm,
   input  logic [1:0]        acc,
   output logic [1:0]        fault
);

   logic [PERM_W-1:0] grant;

   for (genvar k = 0; k < PERM_W; k++) begin : g_grant
      assign grant[k] = pte_perm[k] && (acc == 2'(k));
   end

   always_comb begin
      if (!pte_valid)  fault = FLT_INVALID;
      else if (~|grant) fault = FLT_PERM;
      else             fault = FLT_NONE;
   end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
   import xlate_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 20,
   parameter int MEM_AW  = 32,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PA_W   = FRAME_W + OFF_W,
   localparam int PTE_W  = FRAME_W + FRAME_LO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_acc,
   input  logic [MEM_AW-1:0]  tbl_base,
   input  logic [VPN_W:0]     tbl_size,
   input  logic [1:0]         chk_fault,
   input  logic [FRAME_W-1:0] pte_frame,
   input  logic [PTE_W-1:0]   pte_next,
   input  logic               pte_changed,
   output logic [1:0]         acc_q,
   output logic               busy,
   output logic               resp_valid,
   output logic [1:0]         resp_fault,
   output logic [PA_W-1:0]    resp_paddr,
   output logic               mem_rd_en,
   output logic               mem_wr_en,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [PTE_W-1:0]   mem_wdata
);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_EVAL  = 2'd2,
      ST_WBACK = 2'd3
   } state_e;

   state_e            state_q;
   logic [OFF_W-1:0]  off_q;
   logic [MEM_AW-1:0] addr_q;
   logic [PTE_W-1:0]  wdata_q;
   logic [VPN_W-1:0]  req_vpn;
   logic              out_of_range;

   assign req_vpn      = req_vaddr[VA_W-1:OFF_W];
   assign out_of_range = ({1'b0, req_vpn} >= tbl_size);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         off_q      <= '0;
         acc_q      <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         resp_valid <= 1'b0;
         resp_fault <= FLT_NONE;
         resp_paddr <= '0;
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  off_q <= req_vaddr[OFF_W-1:0];
                  acc_q <= req_acc;
                  if (out_of_range) begin
                     resp_valid <= 1'b1;
                     resp_fault <= FLT_RANGE;
                     resp_paddr <= '0;
                  end else begin
                     addr_q  <= tbl_base + MEM_AW'(req_vpn);
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: state_q <= ST_EVAL;
            ST_EVAL: begin
               if (chk_fault != FLT_NONE) begin
                  resp_valid <= 1'b1;
                  resp_fault <= chk_fault;
                  resp_paddr <= '0;
                  state_q    <= ST_IDLE;
               end else begin
                  resp_fault <= FLT_NONE;
                  resp_paddr <= {pte_frame, off_q};
                  if (pte_changed) begin
                     wdata_q <= pte_next;
                     state_q <= ST_WBACK;
                  end else begin
                     resp_valid <= 1'b1;
                     state_q    <= ST_IDLE;
                  end
               end
            end
            ST_WBACK: begin
               resp_valid <= 1'b1;
               state_q    <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign mem_rd_en = (state_q == ST_FETCH);
   assign mem_wr_en = (state_q == ST_WBACK);
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;

endmodule

// File: rtl/page_xlate.sv
module page_xlate
   import xlate_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 20,
   parameter int MEM_AW  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [VA_W-1:0]            req_vaddr,
   input  logic [1:0]                 req_acc,
   input  logic [MEM_AW-1:0]          tbl_base,
   input  logic [VA_W-OFF_W:0]        tbl_size,
   output logic                       busy,
   output logic                       resp_valid,
   output logic [1:0]                 resp_fault,
   output logic [FRAME_W+OFF_W-1:0]   resp_paddr,
   output logic                       mem_rd_en,
   output logic                       mem_wr_en,
   output logic [MEM_AW-1:0]          mem_addr,
   output logic [FRAME_W+FRAME_LO-1:0] mem_wdata,
   input  logic [FRAME_W+FRAME_LO-1:0] mem_rdata
);

   localparam int VPN_W = VA_W - OFF_W;
   localparam int PTE_W = FRAME_W + FRAME_LO;

   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_offset
      $error("page_xlate: OFF_W must lie between 1 and VA_W-1");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("page_xlate: FRAME_W must be at least 1");
   end
   if (MEM_AW < VPN_W) begin : g_bad_memaw
      $error("page_xlate: MEM_AW must hold a full page number");
   end

   logic [1:0]         acc_q;
   logic               pte_valid;
   logic [PERM_W-1:0]  pte_perm;
   logic [FRAME_W-1:0] pte_frame;
   logic [PTE_W-1:0]   pte_next;
   logic               pte_changed;
   logic [1:0]         chk_fault;

   xlate_pte_update #(.FRAME_W(FRAME_W)) u_pte (
      .pte         (mem_rdata),
      .acc         (acc_q),
      .pte_valid   (pte_valid),
      .pte_perm    (pte_perm),
      .pte_frame   (pte_frame),
      .pte_next    (pte_next),
      .pte_changed (pte_changed)
   );

   xlate_rules u_rules (
      .pte_valid (pte_valid),
      .pte_perm  (pte_perm),
      .acc       (acc_q),
      .fault     (chk_fault)
   );

   xlate_ctrl #(
      .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_vaddr   (req_vaddr),
      .req_acc     (req_acc),
      .tbl_base    (tbl_base),
      .tbl_size    (tbl_size),
      .chk_fault   (chk_fault),
      .pte_frame   (pte_frame),
      .pte_next    (pte_next),
      .pte_changed (pte_changed),
      .acc_q       (acc_q),
      .busy        (busy),
      .resp_valid  (resp_valid),
      .resp_fault  (resp_fault),
      .resp_paddr  (resp_paddr),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata)
   );

endmodule

// File: rtl/xlate_props.sv
module xlate_props #(
   parameter int MEM_AW = 32,
   parameter int PTE_W  = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              resp_valid,
   input logic [1:0]        resp_fault,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [PTE_W-1:0]  mem_wdata
);

   // R3: a table read only happens inside a lookup
   p_read_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   // R8: a write-back comes two cycles after the read, at the same address
   p_wb_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(mem_rd_en, 2));

   p_wb_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_addr == $past(mem_addr, 2)));

   // R8: the written entry is valid and marked referenced
   p_wb_sets_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wdata[0] && mem_wdata[1]));

   // R9: read and write-back never overlap
   p_no_rd_wr_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   // R4: invalid or permission faults follow a read two cycles earlier
   p_entry_fault_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_fault[1]) |-> $past(mem_rd_en, 2));

   // R1: nothing is active right after reset is released
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!resp_valid && !busy && !mem_rd_en && !mem_wr_en));

endmodule

bind page_xlate xlate_props #(.MEM_AW(MEM_AW), .PTE_W(PTE_W)) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .resp_valid (resp_valid),
   .resp_fault (resp_fault),
   .mem_rd_en  (mem_rd_en),
   .mem_wr_en  (mem_wr_en),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata)
);

// File: tb/page_xlate_bench.sv
module page_xlate_bench;

   localparam int VA_W    = 32;
   localparam int OFF_W   = 12;
   localparam int FRAME_W = 20;
   localparam int MEM_AW  = 32;
   localparam int VPN_W   = VA_W - OFF_W;
   localparam int PTE_W   = FRAME_W + 6;
   localparam int PA_W    = FRAME_W + OFF_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               req_valid = 1'b0;
   logic [VA_W-1:0]    req_vaddr = '0;
   logic [1:0]         req_acc = '0;
   logic [MEM_AW-1:0]  tbl_base = '0;
   logic [VPN_W:0]     tbl_size = '0;
   logic               busy, resp_valid, mem_rd_en, mem_wr_en;
   logic [1:0]         resp_fault;
   logic [PA_W-1:0]    resp_paddr;
   logic [MEM_AW-1:0]  mem_addr;
   logic [PTE_W-1:0]   mem_wdata;
   logic [PTE_W-1:0]   mem_rdata = '0;
   logic [PTE_W-1:0]   ptmem [64];

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   page_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)) u_page_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .tbl_base(tbl_base), .tbl_size(tbl_size), .busy(busy),
      .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= ptmem[mem_addr[5:0]];
      if (mem_wr_en) ptmem[mem_addr[5:0]] <= mem_wdata;
   end

   function automatic logic [PTE_W-1:0] mkpte(bit v, bit r, bit d, logic [2:0] perm,
                                              logic [FRAME_W-1:0] frame);
      return {frame, perm, d, r, v};
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural model of one lookup, compared on every cycle until idle again
   task automatic lookup(int vpn, int off, int acc, int base, int size, bit hold, string tag);
      int idx, lat, exp_fault, dl;
      bit range, wb;
      logic [PTE_W-1:0] e, e_new;
      longint exp_pa;
      idx   = base + vpn;
      range = (vpn >= size);
      e     = range ? '0 : ptmem[idx];
      e_new = e;
      exp_fault = 0;
      if (range)                                    exp_fault = 1;
      else if (!e[0])                               exp_fault = 2;
      else if (acc == 3 || !e[3 + acc])             exp_fault = 3;
      if (exp_fault == 0) begin
         e_new[1] = 1'b1;
         if (acc == 1) e_new[2] = 1'b1;
      end
      wb     = (exp_fault == 0) && (e_new != e);
      lat    = range ? 1 : (wb ? 4 : 3);
      exp_pa = (longint'(e[PTE_W-1:6]) << OFF_W) | longint'(off);
      dl     = hold ? lat - 1 : 1;

      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = VA_W'((longint'(vpn) << OFF_W) | longint'(off));
      req_acc   = 2'(acc);
      tbl_base  = MEM_AW'(base);
      tbl_size  = (VPN_W+1)'(size);
      for (int n = 1; n <= lat + 1; n++) begin
         @(negedge clk);
         if (n == 1 && hold) req_vaddr = '1;
         if (n == dl) req_valid = 1'b0;
         chk(resp_valid == (n == lat), {tag, " R10 resp timing"}, resp_valid, n == lat);
         chk(mem_rd_en == (!range && n == 1), {tag, " R3 read strobe"}, mem_rd_en, !range && n == 1);
         chk(mem_wr_en == (wb && n == 3), {tag, " R8 R9 write strobe"}, mem_wr_en, wb && n == 3);
         if (n == 1) chk(busy == !range, {tag, " R11 busy"}, busy, !range);
         if (n == 1 && !range)
            chk(mem_addr == MEM_AW'(idx), {tag, " R3 read address"}, mem_addr, idx);
         if (n == lat) begin
            chk(resp_fault == 2'(exp_fault), {tag, " R2 R4 R5 R6 fault code"}, resp_fault, exp_fault);
            if (exp_fault == 0)
               chk(resp_paddr == PA_W'(exp_pa), {tag, " R7 physical address"}, resp_paddr, exp_pa);
         end
      end
      if (!range)
         chk(ptmem[idx] == e_new, {tag, " R8 stored entry"}, ptmem[idx], e_new);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) ptmem[i] = '0;
      ptmem[16] = mkpte(1, 0, 0, 3'b011, 20'hABCDE);
      ptmem[17] = mkpte(0, 0, 0, 3'b000, 20'h11111);
      ptmem[18] = mkpte(1, 1, 0, 3'b001, 20'h12345);
      ptmem[19] = mkpte(1, 1, 0, 3'b100, 20'h00777);
      ptmem[20] = mkpte(1, 1, 1, 3'b111, 20'hFFFFF);
      ptmem[23] = mkpte(1, 0, 0, 3'b011, 20'h00005);
      ptmem[24] = mkpte(1, 0, 0, 3'b111, 20'h22222);
      ptmem[40] = mkpte(1, 0, 0, 3'b001, 20'h00003);

      repeat (3) @(negedge clk);
      chk(!resp_valid && !busy && !mem_rd_en && !mem_wr_en, "R1 in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!resp_valid && !busy && !mem_rd_en && !mem_wr_en, "R1 after reset", resp_valid, 0);

      lookup(0, 12'h123, 0, 16, 8, 0, "first read sets ref R8");
      lookup(0, 12'hFFF, 0, 16, 8, 0, "repeat read no writeback R8");
      lookup(0, 12'h000, 1, 16, 8, 0, "write sets dirty R8");
      lookup(2, 12'h456, 1, 16, 8, 0, "write to read-only R5 R9");
      lookup(1, 12'h010, 0, 16, 8, 0, "invalid entry R4");
      lookup(8, 12'h020, 0, 16, 8, 0, "page equal to size R2");
      lookup(1, 12'h030, 1, 16, 8, 0, "invalid over permission R6");
      lookup(9, 12'h040, 3, 16, 8, 0, "range over all R6");
      lookup(3, 12'hABC, 2, 16, 8, 0, "execute allowed R7");
      lookup(3, 12'hABC, 0, 16, 8, 0, "read on execute-only R5");
      lookup(4, 12'h001, 3, 16, 8, 0, "reserved access R5");
      lookup(4, 12'h002, 1, 16, 8, 0, "write flags already set R8");
      lookup(7, 12'h7F7, 0, 16, 8, 1, "last page with busy request R11");
      lookup(0, 12'h100, 0, 16, 0, 0, "empty table R2");
      lookup(0, 12'h5A5, 0, 40, 2, 0, "moved table base R3");
      lookup(8, 12'h5A5, 0, 16, 9, 0, "enlarged table R2");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired R10 actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule